// File: doc/BRIEF.md
# Transmit Abort and Status Controller

This block sits next to an Ethernet transmit engine that can run in half or full duplex. While a frame transmission is in progress, it watches collision reports, the carrier-busy line and the frame's length. From these it decides whether the transmission ends normally, is cancelled by the host, or must be aborted. The causes of an abort are:

- too many retries;
- a collision after the configured window;
- a collision at or after byte 64;
- the medium staying busy past a deferral limit;
- a frame that is too long.

When a transmission ends, the block drops the transmit request and updates the sticky status bits. It then asks for a status vector to be written one location past the frame's end pointer, and sends one-cycle event pulses to the interrupt-flag logic. The packet is never retried automatically after an abort.

The host starts a transmission with a one-cycle `go` pulse, which also latches the end pointer. The transmit engine reports collisions (with the byte count at which each one occurred) and reports normal completion with `tx_done`. Backoff timing and serialization belong to the engine.

Top module: `txab_ctrl`

## Requirements
- R1: After reset, `tx_req`, `abort_st`, `late_st`, `sv_wr`, `evt_abort` and `evt_done` are all 0.
- R2: A `go` pulse while idle sets `tx_req` on the next cycle and latches `end_ptr`. A later `tx_done` clears `tx_req` and pulses `sv_wr` and `evt_done` for one cycle, with `sv_addr` equal to the latched end pointer plus 1. `abort_st` stays 0.
- R3: In half duplex, a collision whose byte count is below 64 and not above `cfg_col_win` is counted. The collision that makes the count exceed `cfg_max_retry` aborts the frame. Earlier collisions leave `tx_req` at 1.
- R4: In half duplex, a collision whose byte count is above `cfg_col_win` and below 64 aborts the frame. `late_st` is left unchanged.
- R5: In half duplex, a collision whose byte count is 64 or more aborts the frame and sets `late_st`.
- R6: In half duplex with `cfg_defer_wait`=0, `DEFER_CYCLES` consecutive cycles of `medium_busy` during a transmission abort it. Fewer consecutive busy cycles do not abort it. With `cfg_defer_wait`=1, busy never aborts.
- R7: While active, `frame_len` > `cfg_max_len` aborts the frame, unless `cfg_huge_en`=1 or both `pkt_override`=1 and `pkt_huge`=1.
- R8: With `cfg_full_dup`=1, collisions and busy never abort a frame. Only the oversize cause can.
- R9: An abort clears `tx_req`, sets `abort_st`, and pulses `sv_wr` (at end pointer plus 1), `evt_abort` and `evt_done` together for one cycle. `tx_req` then stays 0 until the next `go`.
- R10: `abort_st` and `late_st` stay set until `host_clr_abort` or `host_clr_late` respectively is pulsed. A clear takes effect on the next cycle.
- R11: A `host_cancel` pulse during a transmission clears `tx_req` and pulses `evt_done` without `evt_abort`. `abort_st` stays 0 and no `sv_wr` is issued.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| go | input | 1 | Host transmit request pulse |
| host_cancel | input | 1 | Host clears its request (cancel) |
| host_clr_abort | input | 1 | Clear abort status |
| host_clr_late | input | 1 | Clear late-collision status |
| end_ptr | input | ADDR_W | Frame end address, latched on go |
| frame_len | input | LEN_W | Frame length in bytes |
| col_evt | input | 1 | Collision reported this cycle |
| col_byte | input | LEN_W | Bytes sent when collision occurred |
| medium_busy | input | 1 | Carrier busy |
| tx_done | input | 1 | Engine finished the frame normally |
| cfg_max_retry | input | RETRY_W | Maximum retransmissions |
| cfg_col_win | input | WIN_W | Collision window in bytes |
| cfg_max_len | input | LEN_W | Maximum frame length |
| cfg_huge_en | input | 1 | Allow frames of any length |
| pkt_override | input | 1 | Per-packet override active |
| pkt_huge | input | 1 | Per-packet huge-frame allow |
| cfg_defer_wait | input | 1 | 1: wait for the medium forever |
| cfg_full_dup | input | 1 | Full-duplex mode |
| tx_req | output | 1 | Transmission in progress |
| abort_st | output | 1 | Sticky abort status |
| late_st | output | 1 | Sticky late-collision status |
| sv_wr | output | 1 | Status vector write strobe |
| sv_addr | output | ADDR_W | Status vector address |
| evt_abort | output | 1 | One-cycle abort event |
| evt_done | output | 1 | One-cycle completion event |

## Verification
The assertions assume several things about the inputs:

- `go`, `host_cancel`, `tx_done` and the clear inputs are single-cycle pulses.
- The configuration stays stable during a transmission.
- A collision is reported by a one-cycle `col_evt` together with its byte count.

The bench drives every input on the falling clock edge, using one-cycle pulses only. It changes the configuration only while the block is idle, and a new vector or test is started only after the previous transmission has ended.

// File: rtl/txab_pkg.sv
package txab_pkg;
  typedef enum logic [2:0] {
    CZ_NONE, CZ_CANCEL, CZ_OVERSIZE, CZ_LATE64,
    CZ_LATEWIN, CZ_RETRY, CZ_DEFER, CZ_DONE
  } cause_e;

  function automatic logic is_abort(cause_e c);
    return (c == CZ_OVERSIZE) || (c == CZ_LATE64) || (c == CZ_LATEWIN) ||
           (c == CZ_RETRY) || (c == CZ_DEFER);
  endfunction
endpackage

// File: rtl/txab_retry.sv
module txab_retry #(
  parameter int RETRY_W = 4
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               start,
  input  logic               count_en,
  input  logic [RETRY_W-1:0] max_retry,
  output logic               limit_hit
);
  localparam int CNT_W = RETRY_W + 1;
  logic [CNT_W-1:0] cnt_q;

  // The collision being counted now would push the total past the maximum
  assign limit_hit = count_en && (cnt_q >= CNT_W'(max_retry));

  always_ff @(posedge clk) begin
    if (rst || start) cnt_q <= '0;
    else if (count_en && !(&cnt_q)) cnt_q <= cnt_q + 1'b1;
  end
endmodule

// File: rtl/txab_defer.sv
module txab_defer #(
  parameter int DEFER_CYCLES = 60718
) (
  input  logic clk,
  input  logic rst,
  input  logic start,
  input  logic enable,
  input  logic busy,
  output logic limit_hit
);
  localparam int CW = $clog2(DEFER_CYCLES + 1);
  localparam logic [CW-1:0] LAST = CW'(DEFER_CYCLES - 1);
  logic [CW-1:0] cnt_q;

  assign limit_hit = enable && busy && (cnt_q == LAST);

  always_ff @(posedge clk) begin
    if (rst || start || !enable || !busy) cnt_q <= '0;
    else if (cnt_q != LAST) cnt_q <= cnt_q + 1'b1;
  end
endmodule

// File: rtl/txab_cause.sv
module txab_cause
  import txab_pkg::*;
#(
  parameter int LEN_W = 11,
  parameter int WIN_W = 8,
  parameter int LATE_BYTES = 64
) (
  input  logic             active,
  input  logic             host_cancel,
  input  logic             tx_done,
  input  logic             col_evt,
  input  logic [LEN_W-1:0] col_byte,
  input  logic [LEN_W-1:0] frame_len,
  input  logic [WIN_W-1:0] cfg_col_win,
  input  logic [LEN_W-1:0] cfg_max_len,
  input  logic             cfg_huge_en,
  input  logic             pkt_override,
  input  logic             pkt_huge,
  input  logic             cfg_full_dup,
  input  logic             retry_hit,
  input  logic             defer_hit,
  output logic             col_count_en,
  output cause_e           cause
);
  localparam int XW = (LEN_W > WIN_W) ? LEN_W : WIN_W;
  logic half_col, past64, past_win, oversize;

  assign half_col = active && col_evt && !cfg_full_dup;
  assign past64   = XW'(col_byte) >= XW'(LATE_BYTES);
  assign past_win = XW'(col_byte) > XW'(cfg_col_win);
  assign oversize = (frame_len > cfg_max_len) && !cfg_huge_en &&
                    !(pkt_override && pkt_huge);
  assign col_count_en = half_col && !past64 && !past_win;

  always_comb begin
    cause = CZ_NONE;
    if (!active)                    cause = CZ_NONE;
    else if (host_cancel)           cause = CZ_CANCEL;
    else if (oversize)              cause = CZ_OVERSIZE;
    else if (half_col && past64)    cause = CZ_LATE64;
    else if (half_col && past_win)  cause = CZ_LATEWIN;
    else if (retry_hit)             cause = CZ_RETRY;
    else if (defer_hit)             cause = CZ_DEFER;
    else if (tx_done)               cause = CZ_DONE;
  end
endmodule

// File: rtl/txab_ctrl.sv
module txab_ctrl
  import txab_pkg::*;
#(
  parameter int LEN_W        = 11,
  parameter int ADDR_W       = 13,
  parameter int RETRY_W      = 4,
  parameter int WIN_W        = 8,
  parameter int LATE_BYTES   = 64,
  parameter int DEFER_CYCLES = 60718
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              go,
  input  logic              host_cancel,
  input  logic              host_clr_abort,
  input  logic              host_clr_late,
  input  logic [ADDR_W-1:0] end_ptr,
  input  logic [LEN_W-1:0]  frame_len,
  input  logic              col_evt,
  input  logic [LEN_W-1:0]  col_byte,
  input  logic              medium_busy,
  input  logic              tx_done,
  input  logic [RETRY_W-1:0] cfg_max_retry,
  input  logic [WIN_W-1:0]  cfg_col_win,
  input  logic [LEN_W-1:0]  cfg_max_len,
  input  logic              cfg_huge_en,
  input  logic              pkt_override,
  input  logic              pkt_huge,
  input  logic              cfg_defer_wait,
  input  logic              cfg_full_dup,
  output logic              tx_req,
  output logic              abort_st,
  output logic              late_st,
  output logic              sv_wr,
  output logic [ADDR_W-1:0] sv_addr,
  output logic              evt_abort,
  output logic              evt_done
);
  logic              active_q;
  logic [ADDR_W-1:0] end_q;
  logic              start, col_count_en, retry_hit, defer_hit, ab_now, late_now;
  cause_e            cause;

  assign start  = go && !active_q;
  assign tx_req = active_q;

  txab_retry #(.RETRY_W(RETRY_W)) u_retry (
    .clk(clk), .rst(rst), .start(start), .count_en(col_count_en),
    .max_retry(cfg_max_retry), .limit_hit(retry_hit));

  txab_defer #(.DEFER_CYCLES(DEFER_CYCLES)) u_defer (
    .clk(clk), .rst(rst), .start(start),
    .enable(active_q && !cfg_full_dup && !cfg_defer_wait),
    .busy(medium_busy), .limit_hit(defer_hit));

  txab_cause #(.LEN_W(LEN_W), .WIN_W(WIN_W), .LATE_BYTES(LATE_BYTES)) u_cause (
    .active(active_q), .host_cancel(host_cancel), .tx_done(tx_done),
    .col_evt(col_evt), .col_byte(col_byte), .frame_len(frame_len),
    .cfg_col_win(cfg_col_win), .cfg_max_len(cfg_max_len),
    .cfg_huge_en(cfg_huge_en), .pkt_override(pkt_override), .pkt_huge(pkt_huge),
    .cfg_full_dup(cfg_full_dup), .retry_hit(retry_hit), .defer_hit(defer_hit),
    .col_count_en(col_count_en), .cause(cause));

  assign ab_now   = is_abort(cause);
  assign late_now = (cause == CZ_LATE64);

  // Transmission sequencing and end-of-frame strobes
  always_ff @(posedge clk) begin
    if (rst) begin
      active_q  <= 1'b0;
      end_q     <= '0;
      sv_wr     <= 1'b0;
      sv_addr   <= '0;
      evt_abort <= 1'b0;
      evt_done  <= 1'b0;
    end else begin
      sv_wr     <= 1'b0;
      evt_abort <= 1'b0;
      evt_done  <= 1'b0;
      if (start) begin
        active_q <= 1'b1;
        end_q    <= end_ptr;
      end else if (cause != CZ_NONE) begin
        active_q  <= 1'b0;
        evt_done  <= 1'b1;
        evt_abort <= ab_now;
        if (cause != CZ_CANCEL) begin
          sv_wr   <= 1'b1;
          sv_addr <= end_q + 1'b1;
        end
      end
    end
  end

  // Sticky status: a set wins over a simultaneous host clear
  always_ff @(posedge clk) begin
    if (rst) begin
      abort_st <= 1'b0;
      late_st  <= 1'b0;
    end else begin
      abort_st <= ab_now   | (abort_st & ~host_clr_abort);
      late_st  <= late_now | (late_st  & ~host_clr_late);
    end
  end

  a_r9_abort_with_done: assert property (@(posedge clk) disable iff (rst)
    evt_abort |-> evt_done);
  a_r9_req_dropped: assert property (@(posedge clk) disable iff (rst)
    evt_done |-> !tx_req);
  a_r9_abort_sets_status: assert property (@(posedge clk) disable iff (rst)
    evt_abort |-> abort_st);
  a_r10_abort_sticky: assert property (@(posedge clk) disable iff (rst)
    abort_st && !host_clr_abort |=> abort_st);
  a_r10_late_sticky: assert property (@(posedge clk) disable iff (rst)
    late_st && !host_clr_late |=> late_st);
  a_r8_no_late_in_full: assert property (@(posedge clk) disable iff (rst)
    cfg_full_dup && !late_st |=> !late_st);
  a_r11_cancel_no_abort: assert property (@(posedge clk) disable iff (rst)
    tx_req && host_cancel |=> evt_done && !evt_abort && !sv_wr);
  a_r2_wr_single: assert property (@(posedge clk) disable iff (rst)
    sv_wr |=> !sv_wr);
endmodule

// File: tb/txab_ctrl_bench.sv
module txab_ctrl_bench;
  localparam int LEN_W = 11, ADDR_W = 13, RETRY_W = 4, WIN_W = 8, DEFER = 16;

  logic clk = 0, rst = 1;
  logic go = 0, host_cancel = 0, host_clr_abort = 0, host_clr_late = 0;
  logic [ADDR_W-1:0] end_ptr = '0;
  logic [LEN_W-1:0]  frame_len = 11'd100, col_byte = '0, cfg_max_len = 11'd1518;
  logic col_evt = 0, medium_busy = 0, tx_done = 0;
  logic [RETRY_W-1:0] cfg_max_retry = 4'd15;
  logic [WIN_W-1:0]   cfg_col_win = 8'd63;
  logic cfg_huge_en = 0, pkt_override = 0, pkt_huge = 0, cfg_defer_wait = 0, cfg_full_dup = 0;
  logic tx_req, abort_st, late_st, sv_wr, evt_abort, evt_done;
  logic [ADDR_W-1:0] sv_addr;

  int errors = 0, checks = 0;
  int n_done = 0, n_abort = 0, n_wr = 0;
  logic [ADDR_W-1:0] last_addr = '0;

  always #5 clk = ~clk;

  txab_ctrl #(.LEN_W(LEN_W), .ADDR_W(ADDR_W), .RETRY_W(RETRY_W), .WIN_W(WIN_W),
              .DEFER_CYCLES(DEFER)) u_txab_ctrl (
    .clk(clk), .rst(rst), .go(go), .host_cancel(host_cancel),
    .host_clr_abort(host_clr_abort), .host_clr_late(host_clr_late),
    .end_ptr(end_ptr), .frame_len(frame_len), .col_evt(col_evt), .col_byte(col_byte),
    .medium_busy(medium_busy), .tx_done(tx_done), .cfg_max_retry(cfg_max_retry),
    .cfg_col_win(cfg_col_win), .cfg_max_len(cfg_max_len), .cfg_huge_en(cfg_huge_en),
    .pkt_override(pkt_override), .pkt_huge(pkt_huge), .cfg_defer_wait(cfg_defer_wait),
    .cfg_full_dup(cfg_full_dup), .tx_req(tx_req), .abort_st(abort_st), .late_st(late_st),
    .sv_wr(sv_wr), .sv_addr(sv_addr), .evt_abort(evt_abort), .evt_done(evt_done));

  // Event monitor, sampled away from the active edge
  always @(negedge clk) begin
    if (!rst) begin
      if (evt_done)  n_done++;
      if (evt_abort) n_abort++;
      if (sv_wr) begin n_wr++; last_addr = sv_addr; end
    end
  end

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic cyc(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic pulse(ref logic s);
    s = 1; @(negedge clk); s = 0;
  endtask

  task automatic clr_events();
    n_done = 0; n_abort = 0; n_wr = 0;
  endtask

  task automatic clear_status();
    host_clr_abort = 1; host_clr_late = 1; @(negedge clk);
    host_clr_abort = 0; host_clr_late = 0; @(negedge clk);
  endtask

  typedef struct packed {
    logic [LEN_W-1:0]   len;
    logic [LEN_W-1:0]   maxl;
    logic               huge;
    logic               ovr;
    logic               phuge;
    logic               fdx;
    logic [3:0]         ncol;
    logic [LEN_W-1:0]   cbyte;
    logic [RETRY_W-1:0] maxr;
    logic [WIN_W-1:0]   win;
    logic               exp_ab;
    logic               exp_late;
  } vec_t;

  localparam int NV = 10;
  localparam vec_t VECS [NV] = '{
    '{11'd100,  11'd1518, 1'b0, 1'b0, 1'b0, 1'b0, 4'd0, 11'd0,  4'd15, 8'd63, 1'b0, 1'b0}, // R2 plain
    '{11'd1600, 11'd1518, 1'b0, 1'b0, 1'b0, 1'b0, 4'd0, 11'd0,  4'd15, 8'd63, 1'b1, 1'b0}, // R7 oversize
    '{11'd1600, 11'd1518, 1'b1, 1'b0, 1'b0, 1'b0, 4'd0, 11'd0,  4'd15, 8'd63, 1'b0, 1'b0}, // R7 huge
    '{11'd1600, 11'd1518, 1'b0, 1'b1, 1'b1, 1'b0, 4'd0, 11'd0,  4'd15, 8'd63, 1'b0, 1'b0}, // R7 override
    '{11'd100,  11'd1518, 1'b0, 1'b0, 1'b0, 1'b0, 4'd3, 11'd10, 4'd2,  8'd63, 1'b1, 1'b0}, // R3 exceed
    '{11'd100,  11'd1518, 1'b0, 1'b0, 1'b0, 1'b0, 4'd2, 11'd10, 4'd2,  8'd63, 1'b0, 1'b0}, // R3 at limit
    '{11'd100,  11'd1518, 1'b0, 1'b0, 1'b0, 1'b0, 4'd1, 11'd70, 4'd15, 8'd63, 1'b1, 1'b1}, // R5 late64
    '{11'd100,  11'd1518, 1'b0, 1'b0, 1'b0, 1'b0, 4'd1, 11'd40, 4'd15, 8'd30, 1'b1, 1'b0}, // R4 window
    '{11'd100,  11'd1518, 1'b0, 1'b0, 1'b0, 1'b1, 4'd5, 11'd70, 4'd0,  8'd63, 1'b0, 1'b0}, // R8 fdx cols
    '{11'd1600, 11'd1518, 1'b0, 1'b0, 1'b0, 1'b1, 4'd0, 11'd0,  4'd15, 8'd63, 1'b1, 1'b0}  // R8 fdx oversize
  };

  initial begin
    fork
      begin
        cyc(3);
        chk("R1 tx_req", tx_req, 0);
        chk("R1 abort_st", abort_st, 0);
        chk("R1 late_st", late_st, 0);
        chk("R1 events", int'(sv_wr) + int'(evt_abort) + int'(evt_done), 0);
        rst = 0;
        cyc(2);

        // Table walk: R2 R3 R4 R5 R7 R8 R9
        for (int v = 0; v < NV; v++) begin
          frame_len = VECS[v].len; cfg_max_len = VECS[v].maxl;
          cfg_huge_en = VECS[v].huge; pkt_override = VECS[v].ovr; pkt_huge = VECS[v].phuge;
          cfg_full_dup = VECS[v].fdx; cfg_max_retry = VECS[v].maxr; cfg_col_win = VECS[v].win;
          end_ptr = ADDR_W'(200 + 16 * v);
          clr_events();
          pulse(go);
          chk($sformatf("R2 v%0d req set", v), tx_req, !(VECS[v].len > VECS[v].maxl) ? 1 :
              ((VECS[v].huge || (VECS[v].ovr && VECS[v].phuge)) ? 1 : 1));
          for (int c = 0; c < int'(VECS[v].ncol); c++) begin
            col_byte = VECS[v].cbyte; pulse(col_evt);
          end
          cyc(1);
          pulse(tx_done);
          cyc(2);
          chk($sformatf("R9 v%0d abort_st", v), abort_st, VECS[v].exp_ab);
          chk($sformatf("R5 v%0d late_st", v), late_st, VECS[v].exp_late);
          chk($sformatf("R9 v%0d evt_abort count", v), n_abort, VECS[v].exp_ab);
          chk($sformatf("R2 v%0d evt_done count", v), n_done, 1);
          chk($sformatf("R2 v%0d sv_wr count", v), n_wr, 1);
          chk($sformatf("R2 v%0d sv_addr", v), int'(last_addr), 200 + 16 * v + 1);
          chk($sformatf("R9 v%0d req clear", v), tx_req, 0);
          clear_status();
        end
        cfg_full_dup = 0; frame_len = 11'd100; cfg_max_retry = 4'd15; cfg_col_win = 8'd63;
        cfg_huge_en = 0; pkt_override = 0; pkt_huge = 0;

        // R3: collisions below the limit keep the request up
        cfg_max_retry = 4'd1; clr_events(); pulse(go);
        col_byte = 11'd5; pulse(col_evt); cyc(1);
        chk("R3 first collision retried", tx_req, 1);
        pulse(col_evt); cyc(1);
        chk("R3 second collision aborts", tx_req, 0);
        chk("R9 abort events together", n_abort * 10 + n_done, 11);
        cyc(5);
        chk("R9 no automatic retry", tx_req, 0);
        // R10: sticky until cleared
        chk("R10 abort sticky", abort_st, 1);
        pulse(host_clr_abort); cyc(1);
        chk("R10 abort cleared", abort_st, 0);
        cfg_max_retry = 4'd15;

        // R10: late bit sticky and cleared separately
        clr_events(); pulse(go); col_byte = 11'd64; pulse(col_evt); cyc(4);
        chk("R10 late sticky", late_st, 1);
        pulse(host_clr_abort); cyc(1);
        chk("R10 late unaffected by abort clear", late_st, 1);
        pulse(host_clr_late); cyc(1);
        chk("R10 late cleared", late_st, 0);

        // R6: busy for DEFER-1 cycles does not abort, DEFER cycles do
        clr_events(); pulse(go);
        medium_busy = 1; cyc(DEFER - 1); medium_busy = 0; cyc(2);
        chk("R6 short busy no abort", tx_req, 1);
        medium_busy = 1; cyc(DEFER); medium_busy = 0; cyc(1);
        chk("R6 deferral abort", abort_st, 1);
        chk("R6 deferral req clear", tx_req, 0);
        clear_status();

        // R6: defer-wait mode never aborts on busy
        cfg_defer_wait = 1; clr_events(); pulse(go);
        medium_busy = 1; cyc(3 * DEFER); medium_busy = 0; cyc(1);
        chk("R6 defer wait keeps request", tx_req, 1);
        pulse(tx_done); cyc(1);
        chk("R6 defer wait no abort", abort_st, 0);
        cfg_defer_wait = 0;

        // R8: full duplex ignores busy
        cfg_full_dup = 1; clr_events(); pulse(go);
        medium_busy = 1; cyc(3 * DEFER); medium_busy = 0; cyc(1);
        chk("R8 full duplex ignores busy", tx_req, 1);
        pulse(tx_done); cyc(1);
        chk("R8 full duplex no abort", abort_st, 0);
        cfg_full_dup = 0;

        // R11: host cancel
        clr_events(); pulse(go); cyc(2);
        pulse(host_cancel); cyc(2);
        chk("R11 cancel clears req", tx_req, 0);
        chk("R11 cancel done event", n_done, 1);
        chk("R11 cancel no abort event", n_abort, 0);
        chk("R11 cancel abort_st", abort_st, 0);
        chk("R11 cancel no status write", n_wr, 0);

        // R1: reset mid-transmission returns to idle
        pulse(go); rst = 1; cyc(2);
        chk("R1 reset clears req", tx_req, 0);
        rst = 0; cyc(1);
      end
      begin
        repeat (20000) @(posedge clk);
        errors++; checks++;
        $display("FAIL watchdog expired");
      end
    join_any
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule